// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block is the digital protection supervisor of a step-down point-of-load regulator. Each clock it looks at a digitized output-voltage sample, the programmed voltage setpoint (both in the same code units), a current-limit flag from the sensing path, a temperature code in degrees Celsius, the enable pin with its polarity-select pin, the ramp-in-progress flag of the soft-start generator, and the level of a wired-AND fault line shared with neighbouring regulators. From these it drives the power-stage enable, a power-good flag, the pull-down of the shared fault line, and a sticky code that names the cause of the most recent protective shutdown.

Every fault condition must persist for a programmable number of time-base ticks before it acts. An overvoltage latches the output off until the supervisor is disabled or reset. All other faults (undervoltage, overcurrent, overtemperature and a low level forced onto the shared line by another module) start a hiccup: the output stays off for a fixed retry period and then turns on again. Overtemperature has hysteresis, so a retry is held back until the die has cooled. The time base is a prescaler on the system clock, so the qualify window and the hiccup period scale with the clock rate through parameters.

Top module: `pol_fault_supervisor`

## Requirements
- R1: While reset is asserted and right after it, `drive_en`, `pg_good` and `flt_pull` are 0 and `flt_cause` is 0 (none).
- R2: The enable is active-high when `en_pol` is 1 and active-low when `en_pol` is 0. With no fault pending, `drive_en` rises one clock after the enable becomes active. It falls one clock after the enable becomes inactive, whatever the state.
- R3: Overvoltage is the condition `vout*10 > vset*13` and `vout > OVP_FLOOR`. Once qualified, it turns the output off and latches: `flt_pull` = 1 and `flt_cause` = 1, and no retry happens while the enable stays active.
- R4: Making the enable inactive clears the overvoltage latch. `flt_pull` returns to 0, `flt_cause` keeps its value, and a new enable starts the output again.
- R5: Undervoltage is `vout*4 < vset*3`, evaluated only while the output is on and `ramping` is 0. It causes a hiccup with `flt_cause` = 2. A low sample while ramping is ignored.
- R6: A condition that lasts for DET_TICKS consecutive ticks turns the output off on the next clock. A condition that lasts for fewer ticks has no effect.
- R7: A retrying fault (causes 2 to 5) drives `flt_pull` = 1 and holds `drive_en` at 0 for exactly HICCUP_TICKS ticks. The output then turns on again. If the fault is still present, it trips again.
- R8: Overtemperature becomes active when `temp_c > OT_TRIP` and stays active until `temp_c < OT_CLEAR`. It causes a hiccup with `flt_cause` = 4. A retry, and a turn-on from off, happen only while it is inactive.
- R9: A qualified `oc_flag` causes a hiccup with `flt_cause` = 3.
- R10: A low `flt_line_in` that this block is not pulling causes a hiccup with `flt_cause` = 5.
- R11: `pg_good` is 1 only while the output is on, `ramping` is 0 and `vset*9 <= vout*10 <= vset*11`. It rises one clock after entering the window. It falls one clock after `ramping` rises, or DET_TICKS+1 ticks after the sample leaves the window.
- R12: `flt_cause` holds its value until `pg_good` next rises, and then becomes 0.
- R13: When several faults qualify together, overvoltage wins. Among the rest, the priority is overtemperature, then overcurrent, then undervoltage, then the external line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable pin level |
| en_pol | input | 1 | Enable polarity select (1 = active-high) |
| vout | input | VW | Output-voltage sample code |
| vset | input | VW | Output-voltage setpoint code |
| oc_flag | input | 1 | Overcurrent flag from current sensing |
| temp_c | input | TW | Die temperature, degrees Celsius |
| ramping | input | 1 | Soft-start ramp in progress |
| flt_line_in | input | 1 | Level of the shared wired-AND fault line |
| drive_en | output | 1 | Power-stage enable |
| pg_good | output | 1 | Power-good flag |
| flt_pull | output | 1 | Pull the shared fault line low |
| flt_cause | output | 3 | Sticky cause: 0 none, 1 OV, 2 UV, 3 OC, 4 OT, 5 external |

## Verification
The bench runs the time base at one tick per clock, so every latency is an exact number of clock edges. Inputs change at a falling edge and outputs are read at later falling edges. An enable change shows on `drive_en` after one edge. A fault shows after DET_TICKS+1 edges: the bench reads the output still on after DET_TICKS edges and off after one more. A hiccup ends exactly HICCUP_TICKS edges after it starts. Power-good rises one edge after the window is entered, and the window sweep waits DET_TICKS+2 edges per point so that the slower falling edge has settled too.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  // Sticky shutdown cause codes, visible at the top-level port.
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_OV   = 3'd1,
    CAUSE_UV   = 3'd2,
    CAUSE_OC   = 3'd3,
    CAUSE_OT   = 3'd4,
    CAUSE_EXT  = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RUN    = 2'd1,
    ST_HICCUP = 2'd2,
    ST_LATCH  = 2'd3
  } sup_state_e;

  // Slots in the qualified-condition vector.
  localparam int NUM_SRC   = 6;
  localparam int IDX_OV    = 0;
  localparam int IDX_UV    = 1;
  localparam int IDX_OC    = 2;
  localparam int IDX_OT    = 3;
  localparam int IDX_EXT   = 4;
  localparam int IDX_PGOUT = 5;

endpackage

// File: rtl/pfs_tick_gen.sv
module pfs_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);

endmodule

// File: rtl/pfs_qualify.sv
module pfs_qualify #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic hit
);

  localparam int unsigned QW = $clog2(LIMIT + 1);
  localparam logic [QW-1:0] TOP = QW'(LIMIT);

  logic [QW-1:0] cnt_q;
  logic [QW-1:0] cnt_d;
  logic          cnt_en;

  // The count advances only on ticks and saturates at the limit.
  assign cnt_en = tick && (cnt_q != TOP);

  always_comb begin
    if (!raw)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == TOP);

endmodule

// File: rtl/pfs_thresholds.sv
module pfs_thresholds #(
  parameter int unsigned VW        = 12,
  parameter int unsigned TW        = 8,
  parameter int unsigned OVP_FLOOR = 1000,
  parameter int unsigned OT_TRIP   = 120,
  parameter int unsigned OT_CLEAR  = 110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vout,
  input  logic [VW-1:0] vset,
  input  logic [TW-1:0] temp_c,
  output logic          ov_cmp,
  output logic          uv_cmp,
  output logic          in_win,
  output logic          ot_raw
);

  localparam int unsigned PW = VW + 4;
  localparam logic [VW-1:0] FLOOR_C = VW'(OVP_FLOOR);
  localparam logic [TW-1:0] TRIP_C  = TW'(OT_TRIP);
  localparam logic [TW-1:0] CLEAR_C = TW'(OT_CLEAR);

  logic [PW-1:0] out_x10;
  logic [PW-1:0] out_x4;
  logic [PW-1:0] set_x13;
  logic [PW-1:0] set_x11;
  logic [PW-1:0] set_x9;
  logic [PW-1:0] set_x3;
  logic          ot_q;

  // Ratios are compared by cross-multiplying, so no divider is needed.
  always_comb begin
    out_x10 = PW'(vout) * PW'(10);
    out_x4  = PW'(vout) * PW'(4);
    set_x13 = PW'(vset) * PW'(13);
    set_x11 = PW'(vset) * PW'(11);
    set_x9  = PW'(vset) * PW'(9);
    set_x3  = PW'(vset) * PW'(3);
  end

  assign ov_cmp = (out_x10 > set_x13) && (vout > FLOOR_C);
  assign uv_cmp = (out_x4 < set_x3);
  assign in_win = (out_x10 >= set_x9) && (out_x10 <= set_x11);

  // Temperature hysteresis: set above the trip point, held until below clear.
  assign ot_raw = (temp_c > TRIP_C) || (ot_q && !(temp_c < CLEAR_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot_q <= 1'b0;
    else        ot_q <= ot_raw;
  end

endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
  import pfs_pkg::*;
#(
  parameter int unsigned HICCUP_TICKS = 130000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               en_act,
  input  logic               ramping,
  input  logic               in_win,
  input  logic               ot_raw,
  input  logic [NUM_SRC-1:0] hit,
  output logic               drive_en,
  output logic               flt_pull,
  output logic               pg_good,
  output cause_e             cause
);

  localparam int unsigned HW = (HICCUP_TICKS > 1) ? $clog2(HICCUP_TICKS) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(HICCUP_TICKS - 1);

  sup_state_e    state_q, state_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          pg_q, pg_d;
  cause_e        cause_q, cause_d;
  logic          run;
  logic          expire;
  logic          retry_fault;

  function automatic cause_e pick_retry_cause(input logic [NUM_SRC-1:0] h);
    if (h[IDX_OT])      return CAUSE_OT;
    else if (h[IDX_OC]) return CAUSE_OC;
    else if (h[IDX_UV]) return CAUSE_UV;
    else                return CAUSE_EXT;
  endfunction

  assign run         = (state_q == ST_RUN);
  assign expire      = (state_q == ST_HICCUP) && tick && (hcnt_q == H_LAST);
  assign retry_fault = hit[IDX_UV] | hit[IDX_OC] | hit[IDX_OT] | hit[IDX_EXT];

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (en_act && !ot_raw) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!en_act)          state_d = ST_OFF;
        else if (hit[IDX_OV]) state_d = ST_LATCH;
        else if (retry_fault) state_d = ST_HICCUP;
      end
      ST_HICCUP: begin
        if (!en_act)                 state_d = ST_OFF;
        else if (hit[IDX_OV])        state_d = ST_LATCH;
        else if (expire && !ot_raw)  state_d = ST_RUN;
      end
      ST_LATCH: begin
        if (!en_act) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  // Hiccup period counter: runs in ticks while waiting, restarts each period.
  always_comb begin
    if (state_q != ST_HICCUP) hcnt_d = '0;
    else if (expire)          hcnt_d = '0;
    else if (tick)            hcnt_d = hcnt_q + 1'b1;
    else                      hcnt_d = hcnt_q;
  end

  // Power-good: set in window, cleared by ramp or a qualified excursion.
  always_comb begin
    if (!run || ramping) pg_d = 1'b0;
    else if (in_win)     pg_d = 1'b1;
    else if (hit[IDX_PGOUT]) pg_d = 1'b0;
    else                 pg_d = pg_q;
  end

  // Sticky cause: written on each protective shutdown, cleared on good turn-on.
  always_comb begin
    cause_d = cause_q;
    if ((state_q == ST_RUN || state_q == ST_HICCUP) && en_act && hit[IDX_OV]) begin
      cause_d = CAUSE_OV;
    end else if (run && en_act && retry_fault) begin
      cause_d = pick_retry_cause(hit);
    end else if (pg_d && !pg_q) begin
      cause_d = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      hcnt_q  <= '0;
      pg_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      pg_q    <= pg_d;
      cause_q <= cause_d;
    end
  end

  assign drive_en = run;
  assign flt_pull = (state_q == ST_HICCUP) || (state_q == ST_LATCH);
  assign pg_good  = pg_q && run;
  assign cause    = cause_q;

endmodule

// File: rtl/pol_fault_supervisor.sv
module pol_fault_supervisor
  import pfs_pkg::*;
#(
  parameter int unsigned VW           = 12,
  parameter int unsigned TW           = 8,
  parameter int unsigned TICK_DIV     = 100,
  parameter int unsigned DET_TICKS    = 6,
  parameter int unsigned HICCUP_TICKS = 130000,
  parameter int unsigned OVP_FLOOR    = 1000,
  parameter int unsigned OT_TRIP      = 120,
  parameter int unsigned OT_CLEAR     = 110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_pin,
  input  logic          en_pol,
  input  logic [VW-1:0] vout,
  input  logic [VW-1:0] vset,
  input  logic          oc_flag,
  input  logic [TW-1:0] temp_c,
  input  logic          ramping,
  input  logic          flt_line_in,
  output logic          drive_en,
  output logic          pg_good,
  output logic          flt_pull,
  output logic [2:0]    flt_cause
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               tick;
  logic               en_act;
  logic               ov_cmp;
  logic               uv_cmp;
  logic               in_win;
  logic               ot_raw;
  logic [NUM_SRC-1:0] raw_vec;
  logic [NUM_SRC-1:0] hit_vec;
  cause_e             cause;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign en_act = en_pol ? en_pin : !en_pin;

  pfs_tick_gen #(
    .DIV (TICK_DIV)
  ) i_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  pfs_thresholds #(
    .VW        (VW),
    .TW        (TW),
    .OVP_FLOOR (OVP_FLOOR),
    .OT_TRIP   (OT_TRIP),
    .OT_CLEAR  (OT_CLEAR)
  ) i_thr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .vout   (vout),
    .vset   (vset),
    .temp_c (temp_c),
    .ov_cmp (ov_cmp),
    .uv_cmp (uv_cmp),
    .in_win (in_win),
    .ot_raw (ot_raw)
  );

  always_comb begin
    raw_vec            = '0;
    raw_vec[IDX_OV]    = ov_cmp;
    raw_vec[IDX_UV]    = uv_cmp && drive_en && !ramping;
    raw_vec[IDX_OC]    = oc_flag;
    raw_vec[IDX_OT]    = ot_raw;
    raw_vec[IDX_EXT]   = !flt_line_in && !flt_pull;
    raw_vec[IDX_PGOUT] = !in_win;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
    pfs_qualify #(
      .LIMIT (DET_TICKS)
    ) i_q (
      .clk   (clk),
      .rst_n (rst_int_n),
      .tick  (tick),
      .raw   (raw_vec[g]),
      .hit   (hit_vec[g])
    );
  end

  pfs_seq #(
    .HICCUP_TICKS (HICCUP_TICKS)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .en_act   (en_act),
    .ramping  (ramping),
    .in_win   (in_win),
    .ot_raw   (ot_raw),
    .hit      (hit_vec),
    .drive_en (drive_en),
    .flt_pull (flt_pull),
    .pg_good  (pg_good),
    .cause    (cause)
  );

  assign flt_cause = cause;

endmodule

// File: rtl/pfs_sva_chk.sv
module pfs_sva_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_pin,
  input logic       en_pol,
  input logic       ramping,
  input logic       drive_en,
  input logic       pg_good,
  input logic       flt_pull,
  input logic [2:0] flt_cause
);

  logic en_act;
  assign en_act = en_pol ? en_pin : !en_pin;

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> !drive_en);

  // R3
  ov_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_pull && en_act && flt_cause == 3'd1) |=> (flt_pull && !drive_en));

  // R7
  trip_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && en_act) |=> (drive_en || flt_pull));

  // R11
  ramp_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramping |=> !pg_good);

  // R12
  pg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_good) |-> (flt_cause == 3'd0));

endmodule

bind pol_fault_supervisor pfs_sva_chk i_sva_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_pin    (en_pin),
  .en_pol    (en_pol),
  .ramping   (ramping),
  .drive_en  (drive_en),
  .pg_good   (pg_good),
  .flt_pull  (flt_pull),
  .flt_cause (flt_cause)
);

// File: tb/test_pol_fault_supervisor.sv
`timescale 1ns/1ps
module test_pol_fault_supervisor;

  localparam int VW  = 10;
  localparam int TW  = 8;
  localparam int DET = 3;
  localparam int H   = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en_pin, en_pol, oc_flag, ramping, ext_drv;
  logic [VW-1:0] vout, vset;
  logic [TW-1:0] temp_c;
  logic          drive_en, pg_good, flt_pull;
  logic [2:0]    flt_cause;
  wire           line_w;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  // Wired-AND shared fault line: this block and a neighbour may pull it low.
  assign line_w = ~(flt_pull | ext_drv);

  pol_fault_supervisor #(
    .VW(VW), .TW(TW), .TICK_DIV(1), .DET_TICKS(DET), .HICCUP_TICKS(H),
    .OVP_FLOOR(100), .OT_TRIP(120), .OT_CLEAR(110)
  ) i_pol_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_pol(en_pol),
    .vout(vout), .vset(vset), .oc_flag(oc_flag), .temp_c(temp_c),
    .ramping(ramping), .flt_line_in(line_w), .drive_en(drive_en),
    .pg_good(pg_good), .flt_pull(flt_pull), .flt_cause(flt_cause)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_run(input int set);
    en_pin = 1'b0; en_pol = 1'b1; oc_flag = 1'b0; temp_c = 8'd25;
    ramping = 1'b0; ext_drv = 1'b0;
    vset = VW'(set); vout = VW'(set);
    wait_n(3);
    en_pin = 1'b1;
    wait_n(4);
    check("R2 start drive", int'(drive_en), 1);
  endtask

  initial begin
    rst_n = 1'b0; en_pin = 1'b0; en_pol = 1'b1; oc_flag = 1'b0;
    ramping = 1'b0; ext_drv = 1'b0; temp_c = 8'd25;
    vset = VW'(200); vout = VW'(200);
    wait_n(4);
    // R1 reset state
    check("R1 drive", int'(drive_en), 0);
    check("R1 pg", int'(pg_good), 0);
    check("R1 pull", int'(flt_pull), 0);
    check("R1 cause", int'(flt_cause), 0);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 after release", int'(drive_en), 0);

    // R2 enable polarity and latency
    en_pin = 1'b1; wait_n(1);
    check("R2 high-active on", int'(drive_en), 1);
    en_pol = 1'b0; wait_n(1);
    check("R2 low-active, pin high", int'(drive_en), 0);
    en_pin = 1'b0; wait_n(1);
    check("R2 low-active, pin low", int'(drive_en), 1);

    // R11 window sweep
    start_run(200);
    for (int s = 151; s <= 259; s++) begin
      vout = VW'(s);
      wait_n(DET + 2);
      check("R11 pg window", int'(pg_good), ((s * 10 >= 1800) && (s * 10 <= 2200)) ? 1 : 0);
      check("R11 drive kept", int'(drive_en), 1);
    end
    vout = VW'(200); wait_n(2);
    ramping = 1'b1; wait_n(1);
    check("R11 ramp drops pg", int'(pg_good), 0);

    // R5 undervoltage masked while ramping
    vout = VW'(0); wait_n(20);
    check("R5 masked during ramp", int'(drive_en), 1);
    vout = VW'(200); ramping = 1'b0; wait_n(2);
    check("R11 pg after ramp", int'(pg_good), 1);

    // R5 threshold and R6 timing
    vout = VW'(150); wait_n(20);
    check("R5 at 75% no trip", int'(drive_en), 1);
    vout = VW'(149); wait_n(DET);
    check("R6 still on after DET", int'(drive_en), 1);
    wait_n(1);
    check("R6 off at DET+1", int'(drive_en), 0);
    check("R5 cause UV", int'(flt_cause), 2);
    check("R7 pull in hiccup", int'(flt_pull), 1);
    vout = VW'(200);
    wait_n(H - 1);
    check("R7 off whole period", int'(drive_en), 0);
    wait_n(1);
    check("R7 retry on time", int'(drive_en), 1);
    check("R7 pull released", int'(flt_pull), 0);
    wait_n(2);
    check("R12 cause cleared", int'(flt_cause), 0);

    // R6 short excursion ignored
    vout = VW'(149); wait_n(DET - 1);
    vout = VW'(200); wait_n(20);
    check("R6 short no trip", int'(drive_en), 1);
    check("R6 short no cause", int'(flt_cause), 0);

    // R9 overcurrent with re-trip (R7)
    oc_flag = 1'b1; wait_n(DET + 1);
    check("R9 off", int'(drive_en), 0);
    check("R9 cause OC", int'(flt_cause), 3);
    wait_n(H);
    check("R7 retry while OC", int'(drive_en), 1);
    wait_n(1);
    check("R7 re-trip", int'(drive_en), 0);
    oc_flag = 1'b0; wait_n(2 * H);
    check("R9 recovered", int'(drive_en), 1);
    check("R12 cause cleared after OC", int'(flt_cause), 0);

    // R8 overtemperature hysteresis
    temp_c = 8'd120; wait_n(20);
    check("R8 at trip no fault", int'(drive_en), 1);
    temp_c = 8'd121; wait_n(DET + 1);
    check("R8 off", int'(drive_en), 0);
    check("R8 cause OT", int'(flt_cause), 4);
    temp_c = 8'd115; wait_n(3 * H);
    check("R8 held off above clear", int'(drive_en), 0);
    temp_c = 8'd109; wait_n(H + 2);
    check("R8 retry after cooling", int'(drive_en), 1);
    wait_n(3);
    check("R12 cause cleared after OT", int'(flt_cause), 0);

    // R10 external pull on shared line
    ext_drv = 1'b1; wait_n(DET + 1);
    check("R10 off", int'(drive_en), 0);
    check("R10 cause EXT", int'(flt_cause), 5);
    check("R10 own pull", int'(flt_pull), 1);
    ext_drv = 1'b0; wait_n(H + 3);
    check("R10 recovered", int'(drive_en), 1);
    check("R10 line released", int'(flt_pull), 0);

    // R3 overvoltage threshold and latch
    vout = VW'(260); wait_n(20);
    check("R3 at 130% no trip", int'(drive_en), 1);
    vout = VW'(261); wait_n(DET + 1);
    check("R3 off", int'(drive_en), 0);
    check("R3 cause OV", int'(flt_cause), 1);
    vout = VW'(200); wait_n(3 * H);
    check("R3 latched", int'(drive_en), 0);
    check("R3 pull held", int'(flt_pull), 1);

    // R4 release by re-enable
    en_pin = 1'b0; wait_n(1);
    check("R4 pull released", int'(flt_pull), 0);
    check("R4 cause sticky", int'(flt_cause), 1);
    en_pin = 1'b1; wait_n(1);
    check("R4 restart", int'(drive_en), 1);
    wait_n(2);
    check("R12 cause cleared after OV", int'(flt_cause), 0);

    // R3 floor at low setpoint
    start_run(50);
    vout = VW'(100); wait_n(20);
    check("R3 floor no trip", int'(drive_en), 1);
    vout = VW'(101); wait_n(DET + 1);
    check("R3 floor trip", int'(flt_cause), 1);

    // R13 priority OV over OC
    start_run(200);
    vout = VW'(300); oc_flag = 1'b1; wait_n(DET + 1);
    check("R13 cause OV wins", int'(flt_cause), 1);
    wait_n(2 * H);
    check("R13 stays latched", int'(drive_en), 0);

    // R13 priority OT over OC
    start_run(200);
    temp_c = 8'd130; oc_flag = 1'b1; wait_n(DET + 1);
    check("R13 cause OT over OC", int'(flt_cause), 4);
    oc_flag = 1'b0; temp_c = 8'd25;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule